// File: doc/BRIEF.md
# Console Character Port Register File

This block sits between a processor's word-wide load/store bus and a character console. It presents four 32-bit registers in a small fixed window near the top of the address space. Two belong to the receive side and two to the send side. Each side has a status/control word and a character word. Software polls the status words, or sets an enable bit and takes an interrupt instead.

On the device side, the receive logic delivers a one-cycle strobe with the incoming character. The block hands each outgoing character to the console as a one-cycle strobe. The console answers with a one-cycle completion pulse once it can accept the next character.

Reading the receive character word or storing to the send character word has a side effect: it clears that side's ready flag. A single level-sensitive interrupt line reports every side whose ready flag is set while its enable bit is on.

Top module: `conio_regfile`

Register map (base `BASE_ADDR` = 0xFFFF0000; only the offsets below are decoded):

| Offset | Register | Contents |
|---|---|---|
| +0x0 | receive control/status | bit 0 = ready, bit 1 = interrupt enable, bits 31:2 = 0 |
| +0x4 | receive character | bits 7:0 = received character, bits 31:8 = 0 |
| +0x8 | send control/status | bit 0 = ready, bit 1 = interrupt enable, bits 31:2 = 0 |
| +0xC | send character | write-only; reads return 0 |

## Requirements
- R1: After reset the receive ready flag is 0, both enable bits are 0 and the send ready flag is 1. So the receive control word at BASE+0x0 reads 0, the send control word at BASE+0x8 reads 1, `irq` is 0 and `tx_strobe` is 0.
- R2: A cycle with `rx_valid` high captures `rx_char` and sets receive ready from the next cycle on. While `bus_rd` is high, `bus_rdata` shows the selected register in the same cycle. A control word reads as {30'b0, enable at bit 1, ready at bit 0}. The receive character word at BASE+0x4 reads as {24'b0, character}.
- R3: A read of BASE+0x4 clears receive ready from the next cycle on. If `rx_valid` is high in that same cycle, the new character is captured and receive ready stays 1.
- R4: A character that arrives while receive ready is 1 overwrites the held character, and receive ready stays 1.
- R5: A store to BASE+0xC clears send ready from the next cycle on. In that next cycle `tx_strobe` is high for one cycle and `tx_char` equals bits 7:0 of the stored word.
- R6: A `tx_done` pulse sets send ready from the next cycle on. A store to BASE+0xC in the same cycle takes priority, and send ready becomes 0.
- R7: A store to a control word writes only its enable bit, from bit 1. Bit 0 and all other bits of the stored word are ignored. Each enable bit keeps its value until its own control word is written.
- R8: `irq` is high exactly when (receive ready AND receive enable) OR (send ready AND send enable). It stays high while that condition holds.
- R9: Any address outside the four decoded offsets reads as 0 and ignores writes. This includes other offsets in the window, misaligned offsets and addresses outside the window. Such writes produce no `tx_strobe`.
- R10: A read of BASE+0xC returns 0 and has no side effect. A store to BASE+0x4 changes neither the held character nor receive ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Store strobe |
| bus_rd | input | 1 | Load strobe |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the cycle `bus_rd` is high |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_char | input | 8 | Received character |
| tx_strobe | output | 1 | One-cycle strobe: a character is handed to the console |
| tx_char | output | 8 | Character sent to the console |
| tx_done | input | 1 | Console pulse: ready for the next character |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that `rx_valid` and `tx_done` are synchronous to `clk`. They also assume that a load and a store are never issued in the same cycle. Under those conditions the single-cycle side effects of a load or store on the ready flags are unambiguous.

The bench issues each bus access as a one-cycle pulse starting on a falling edge and never overlaps a load with a store. It drives the device strobes the same way. It raises `rx_valid` together with a read, or `tx_done` together with a store, only on purpose, to exercise the priority rules.

// File: rtl/conio_pkg.sv
package conio_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CHAR_W    = 8;
  localparam int unsigned READY_BIT = 0;
  localparam int unsigned IE_BIT    = 1;
  localparam int unsigned WIN_LSB   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_CTRL,
    SEL_RX_DATA,
    SEL_TX_CTRL,
    SEL_TX_DATA
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] pack_ctrl(input logic ie, input logic ready);
    logic [WORD_W-1:0] w;
    w            = '0;
    w[IE_BIT]    = ie;
    w[READY_BIT] = ready;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_char(input logic [CHAR_W-1:0] c);
    return {{(WORD_W-CHAR_W){1'b0}}, c};
  endfunction

endpackage

// File: rtl/conio_decode.sv
module conio_decode
  import conio_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [WORD_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam int unsigned HI_W = WORD_W - WIN_LSB;

  logic in_window;
  logic aligned;

  assign in_window = (addr[WORD_W-1:WIN_LSB] == BASE_ADDR[WORD_W-1:WIN_LSB]);
  assign aligned   = (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (in_window && aligned) begin
      case (addr[WIN_LSB-1:2])
        2'd0:    sel = SEL_RX_CTRL;
        2'd1:    sel = SEL_RX_DATA;
        2'd2:    sel = SEL_TX_CTRL;
        default: sel = SEL_TX_DATA;
      endcase
    end
  end

  initial begin
    assert (HI_W > 0) else $error("window wider than address");
  end

endmodule

// File: rtl/conio_rx_chan.sv
module conio_rx_chan
  import conio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_data_hit,
  input  logic              wr_ctrl_hit,
  input  logic              ie_wval,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] held_char
);

  logic load_ev;
  logic drain_ev;

  assign load_ev  = rx_valid;
  assign drain_ev = rd_data_hit && !rx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      ie        <= 1'b0;
      held_char <= '0;
    end else begin
      if (load_ev) begin
        ready     <= 1'b1;
        held_char <= rx_char;
      end else if (drain_ev) begin
        ready <= 1'b0;
      end
      if (wr_ctrl_hit) ie <= ie_wval;
    end
  end

  AST_RX_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> ready && (held_char == $past(rx_char))); // R2
  AST_RX_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_hit && !rx_valid) |=> !ready); // R3
  AST_RX_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rx_valid) |=> ready); // R4
  AST_RX_IE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl_hit |=> $stable(ie)); // R7

endmodule

// File: rtl/conio_tx_chan.sv
module conio_tx_chan
  import conio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data_hit,
  input  logic              wr_ctrl_hit,
  input  logic              ie_wval,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              tx_done,
  output logic              ready,
  output logic              ie,
  output logic              strobe,
  output logic [CHAR_W-1:0] out_char
);

  logic send_ev;
  logic free_ev;

  assign send_ev = wr_data_hit;
  assign free_ev = tx_done && !wr_data_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready    <= 1'b1;
      ie       <= 1'b0;
      strobe   <= 1'b0;
      out_char <= '0;
    end else begin
      strobe <= send_ev;
      if (send_ev) begin
        ready    <= 1'b0;
        out_char <= wchar;
      end else if (free_ev) begin
        ready <= 1'b1;
      end
      if (wr_ctrl_hit) ie <= ie_wval;
    end
  end

  AST_TX_STORE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_hit |=> strobe && (out_char == $past(wchar))); // R5
  AST_TX_STORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_hit |=> !ready); // R5
  AST_TX_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !wr_data_hit) |=> ready); // R6
  AST_TX_IE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl_hit |=> $stable(ie)); // R7

endmodule

// File: rtl/conio_regfile.sv
module conio_regfile
  import conio_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              tx_strobe,
  output logic [CHAR_W-1:0] tx_char,
  input  logic              tx_done,
  output logic              irq
);

  reg_sel_e sel;

  logic rx_ctrl_wr, rx_data_rd, tx_ctrl_wr, tx_data_wr;
  logic rx_ready, rx_ie, tx_ready, tx_ie;
  logic rx_irq_src, tx_irq_src;
  logic [CHAR_W-1:0] rx_held;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata;

  conio_decode #(.BASE_ADDR(BASE_ADDR)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign rx_ctrl_wr = bus_wr && (sel == SEL_RX_CTRL);
  assign rx_data_rd = bus_rd && (sel == SEL_RX_DATA);
  assign tx_ctrl_wr = bus_wr && (sel == SEL_TX_CTRL);
  assign tx_data_wr = bus_wr && (sel == SEL_TX_DATA);

  conio_rx_chan u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data_hit (rx_data_rd),
    .wr_ctrl_hit (rx_ctrl_wr),
    .ie_wval     (bus_wdata[IE_BIT]),
    .rx_valid    (rx_valid),
    .rx_char     (rx_char),
    .ready       (rx_ready),
    .ie          (rx_ie),
    .held_char   (rx_held)
  );

  conio_tx_chan u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_data_hit (tx_data_wr),
    .wr_ctrl_hit (tx_ctrl_wr),
    .ie_wval     (bus_wdata[IE_BIT]),
    .wchar       (bus_wdata[CHAR_W-1:0]),
    .tx_done     (tx_done),
    .ready       (tx_ready),
    .ie          (tx_ie),
    .strobe      (tx_strobe),
    .out_char    (tx_char)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_RX_CTRL: bus_rdata = pack_ctrl(rx_ie, rx_ready);
        SEL_RX_DATA: bus_rdata = pack_char(rx_held);
        SEL_TX_CTRL: bus_rdata = pack_ctrl(tx_ie, tx_ready);
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign rx_irq_src = rx_ready && rx_ie;
  assign tx_irq_src = tx_ready && tx_ie;
  assign irq        = rx_irq_src || tx_irq_src;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (sel == SEL_NONE)) |-> (bus_rdata == '0)); // R9
  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ((sel == SEL_RX_CTRL) || (sel == SEL_TX_CTRL)))
      |-> ((bus_rdata >> (IE_BIT + 1)) == '0)); // R2
  AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ready || tx_ready)); // R8
  AST_UNMAPPED_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (sel == SEL_NONE)) |=> !tx_strobe); // R9

endmodule

// File: tb/conio_regfile_tb.sv
module conio_regfile_tb;

  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam logic [31:0] A_RXC = BASE + 32'h0;
  localparam logic [31:0] A_RXD = BASE + 32'h4;
  localparam logic [31:0] A_TXC = BASE + 32'h8;
  localparam logic [31:0] A_TXD = BASE + 32'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        tx_strobe;
  logic [7:0]  tx_char;
  logic        tx_done = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  conio_regfile #(.BASE_ADDR(BASE)) u_dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rx_valid (rx_valid), .rx_char (rx_char), .tx_strobe (tx_strobe),
    .tx_char (tx_char), .tx_done (tx_done), .irq (irq)
  );

  function automatic logic [31:0] ctrl_exp(input logic ie, input logic rdy);
    return (32'(ie) * 2) + 32'(rdy);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] c);
    rx_valid = 1'b1; rx_char = c;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic done_pulse();
    tx_done = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 tx_strobe", 32'(tx_strobe), 0);
    rd(A_RXC, v); check("R1 rx ctrl", v, 0);
    rd(A_TXC, v); check("R1 tx ctrl", v, 1);

    // R2/R3 sweep over every character
    for (int b = 0; b < 256; b++) begin
      rx_put(8'(b));
      rd(A_RXC, v); check("R2 rx ready set", v, ctrl_exp(0, 1));
      rd(A_RXD, v); check("R2 rx char", v, 32'(b));
      rd(A_RXC, v); check("R3 rx ready cleared", v, ctrl_exp(0, 0));
    end

    // R4 overrun
    rx_put(8'h41); rx_put(8'h42);
    rd(A_RXC, v); check("R4 ready stays", v, 1);
    rd(A_RXD, v); check("R4 overwritten", v, 32'h42);

    // R3 read collides with arrival
    rx_put(8'h10);
    bus_addr = A_RXD; bus_rd = 1'b1; rx_valid = 1'b1; rx_char = 8'h55;
    #1 check("R3 collide old char", bus_rdata, 32'h10);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    rd(A_RXC, v); check("R3 collide ready kept", v, 1);
    rd(A_RXD, v); check("R3 collide new char", v, 32'h55);

    // R5/R6 send sweep
    for (int b = 0; b < 256; b++) begin
      wr(A_TXD, {24'hA5C3_E1, 8'(b)});
      check("R5 strobe", 32'(tx_strobe), 1);
      check("R5 char", 32'(tx_char), 32'(b));
      rd(A_TXC, v); check("R5 busy", v, 0);
      check("R5 strobe one cycle", 32'(tx_strobe), 0);
      done_pulse();
      rd(A_TXC, v); check("R6 done sets ready", v, 1);
    end

    // R6 store beats done
    wr(A_TXD, 32'h61);
    bus_addr = A_TXD; bus_wdata = 32'h62; bus_wr = 1'b1; tx_done = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; tx_done = 1'b0;
    check("R6 collide char", 32'(tx_char), 32'h62);
    rd(A_TXC, v); check("R6 store wins", v, 0);
    done_pulse();

    // R7 control writes
    rd(A_RXD, v);
    wr(A_RXC, 32'hFFFF_FFFF); rd(A_RXC, v); check("R7 rx ie only", v, 2);
    wr(A_TXC, 32'hFFFF_FFFE); rd(A_TXC, v); check("R7 tx ie set", v, 3);
    wr(A_TXC, 32'h0000_0001); rd(A_TXC, v); check("R7 tx ready ignored", v, 1);
    rd(A_RXC, v); check("R7 rx ie held", v, 2);

    // R8 interrupt over all 16 combinations
    for (int k = 0; k < 16; k++) begin
      logic ri, ti, rr, tr;
      {ri, ti, rr, tr} = 4'(k);
      wr(A_RXC, {30'b0, ri, 1'b0});
      wr(A_TXC, {30'b0, ti, 1'b0});
      if (rr) rx_put(8'(k)); else rd(A_RXD, v);
      if (tr) done_pulse(); else wr(A_TXD, 32'(k));
      @(negedge clk);
      check("R8 irq", 32'(irq), 32'((rr & ri) | (tr & ti)));
    end

    // R9 unmapped accesses
    wr(A_RXC, 32'h2); wr(A_TXC, 32'h0); rx_put(8'h3C); done_pulse();
    for (int o = 16; o < 256; o += 4) begin
      wr(BASE + 32'(o), 32'hFFFF_FFFF);
      check("R9 no strobe", 32'(tx_strobe), 0);
      rd(BASE + 32'(o), v); check("R9 window read zero", v, 0);
    end
    for (int o = 1; o < 16; o++) begin
      if ((o % 4) != 0) begin
        wr(BASE + 32'(o), 32'hFFFF_FFFF);
        check("R9 misaligned no strobe", 32'(tx_strobe), 0);
        rd(BASE + 32'(o), v); check("R9 misaligned zero", v, 0);
      end
    end
    wr(32'h0000_0000, 32'hFFFF_FFFF); rd(32'h0000_0000, v); check("R9 low zero", v, 0);
    wr(32'hFFFE_000C, 32'hFFFF_FFFF);
    check("R9 outside no strobe", 32'(tx_strobe), 0);
    rd(32'hFFFE_0000, v); check("R9 outside zero", v, 0);
    rd(A_RXC, v); check("R9 rx ctrl kept", v, 3);
    rd(A_TXC, v); check("R9 tx ctrl kept", v, 1);

    // R10 write-only and read-only data words
    rd(A_TXD, v); check("R10 tx data reads zero", v, 0);
    rd(A_TXC, v); check("R10 tx ready untouched", v, 1);
    wr(A_RXD, 32'h77);
    rd(A_RXC, v); check("R10 rx ready untouched", v, 3);
    rd(A_RXD, v); check("R10 rx char untouched", v, 32'h3C);

    finish_run();
  end

endmodule